// File: doc/BRIEF.md
# Two-Thread Shared Lookup Cache

This block is a small set-associative cache that two hardware threads share. Each thread presents its own next-address pointer together with a request line and a stall line. A fresh arbitration decision is made on every clock, and exactly one thread may look up the arrays in a given cycle. When a thread is stalled or has nothing to ask, the other thread receives every slot. The result of a lookup appears one cycle after its grant. A hit returns the stored line and a miss raises a miss flag.

The requester resolves a miss by sending a fill. The fill writes the line into the addressed set and takes an invalid way if one is free, or otherwise the least recently used way. Every entry records the thread that wrote it. A lookup hits only when both the address tag and that owner match the thread that is asking, so the two threads never see each other's lines even at the same address. A per-thread flush drops only the entries owned by that thread.

Top module: `dtc_cache_top`

## Requirements
- R1: After reset no response is presented and every entry is invalid, so the first lookup of any address misses.
- R2: At most one bit of `grant` is high in a cycle (bit 0 is thread 0 and bit 1 is thread 1). A thread is granted only while its request is high and its stall is low.
- R3: When exactly one thread is eligible (requesting and not stalled), that thread is granted in that cycle.
- R4: When both threads are eligible, the thread that did not win the previous contested cycle is granted. Thread 0 wins the first contest after reset, and uncontested grants do not change the order.
- R5: In the cycle after a grant, `rsp_valid` is high and `rsp_tid` names the granted thread (0 or 1). Exactly one of `rsp_hit` and `rsp_miss` is high. `rsp_line` carries the stored line on a hit and zero on a miss. With no grant, `rsp_valid` is low in the next cycle.
- R6: A lookup hits only when the entry is valid, its tag equals the address tag, and its owner equals the requesting thread. A line filled by one thread misses for the other.
- R7: A fill writes tag, owner and line into the set given by the low `$clog2(SETS)` address bits, and the tag is the remaining upper bits. If the same thread already holds that address, the fill overwrites that entry in place. Otherwise the lowest-numbered invalid way is used, and in a full set the least recently used way is used.
- R8: Hits and fills both mark their way as most recently used, and misses leave the order unchanged. A fill into a full set evicts the way that was touched longest ago.
- R9: A flush for one thread invalidates every entry owned by that thread in all sets within one cycle, and leaves the other thread's entries valid.
- R10: A lookup in the same cycle as a fill or a flush sees the array contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t0_req | input | 1 | Thread 0 wants a lookup this cycle |
| t0_stall | input | 1 | Thread 0 is stalled and yields its slot |
| t0_ptr | input | ADDR_W | Thread 0 next-address pointer |
| t1_req | input | 1 | Thread 1 wants a lookup this cycle |
| t1_stall | input | 1 | Thread 1 is stalled and yields its slot |
| t1_ptr | input | ADDR_W | Thread 1 next-address pointer |
| fill_valid | input | 1 | Write a line this cycle |
| fill_tid | input | 1 | Thread that owns the filled line |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_line | input | LINE_W | Line data to store |
| flush_valid | input | 1 | Invalidate one thread's entries |
| flush_tid | input | 1 | Thread whose entries are dropped |
| grant | output | 2 | One-hot grant for this cycle, bit n for thread n |
| rsp_valid | output | 1 | Lookup result present (one cycle after grant) |
| rsp_tid | output | 1 | Thread the result belongs to |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed |
| rsp_line | output | LINE_W | Stored line on a hit, zero on a miss |

## Verification
The bench builds the block with 8 ways, 4 sets, a 10-bit address and 16-bit lines. With only four sets, eight fills into one set reach a full set, so in-place overwrite, eviction of the least recently touched way, and the survival of a line whose recency was refreshed can all be shown in a short run. The 8-bit tag leaves room for many distinct lines per set. Both thread IDs share addresses, which exposes owner-tag matching, and the flush selectivity is checked across two sets.

// File: rtl/dtc_pkg.sv
// Shared definitions for the two-thread lookup cache.
// Assumes exactly two hardware threads, identified by a one-bit ID.
package dtc_pkg;
    localparam int unsigned THREADS = 2;

    typedef logic [THREADS-1:0] grant_t;

    typedef enum logic {
        THR0 = 1'b0,
        THR1 = 1'b1
    } thread_e;
endpackage

// File: rtl/dtc_arbiter.sv
// Per-cycle arbiter between two thread request ports.
// A thread is eligible while it requests and is not stalled. A lone eligible
// thread always wins. On a contested cycle the thread that did not win the
// last contest is granted. The grant is combinational from the inputs and
// one state bit.
module dtc_arbiter
    import dtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  grant_t req,
    input  grant_t stall,
    output grant_t grant
);
    grant_t elig;
    logic   contested;
    logic   last_q;     // thread that won the most recent contested cycle

    assign elig      = req & ~stall;
    assign contested = &elig;

    // Select the granted thread for this cycle.
    always_comb begin
        if (contested) begin
            grant = last_q ? grant_t'(2'b01) : grant_t'(2'b10);
        end else begin
            grant = elig;
        end
    end

    // Remember the winner of contested cycles only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
        end else if (contested) begin
            last_q <= ~last_q;
        end
    end
endmodule

// File: rtl/dtc_way_store.sv
// Tag, owner, valid and data arrays for all sets and ways.
// Two read views are provided: one for the granted lookup and one that
// probes the set being filled. A flush clears the valid bits owned by one
// thread in every set. A fill in the same cycle is applied after the flush.
// Assumes SETS is a power of two. Payload arrays carry no reset.
module dtc_way_store #(
    parameter int unsigned WAYS   = 8,
    parameter int unsigned SETS   = 16,
    parameter int unsigned TAG_W  = 8,
    parameter int unsigned LINE_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(SETS)-1:0]           rd_set,
    output logic [WAYS-1:0]                   rd_vld,
    output logic [WAYS-1:0]                   rd_own,
    output logic [WAYS-1:0][TAG_W-1:0]        rd_tag,
    output logic [WAYS-1:0][LINE_W-1:0]      rd_data,
    input  logic [$clog2(SETS)-1:0]           pk_set,
    output logic [WAYS-1:0]                   pk_vld,
    output logic [WAYS-1:0]                   pk_own,
    output logic [WAYS-1:0][TAG_W-1:0]        pk_tag,
    input  logic                              wr_en,
    input  logic [$clog2(SETS)-1:0]           wr_set,
    input  logic [$clog2(WAYS)-1:0]           wr_way,
    input  logic [TAG_W-1:0]                  wr_tag,
    input  logic                              wr_own,
    input  logic [LINE_W-1:0]                 wr_line,
    input  logic                              flush_en,
    input  logic                              flush_tid
);
    logic [WAYS-1:0]              vld_q  [SETS];
    logic [WAYS-1:0]              own_q  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_q  [SETS];
    logic [WAYS-1:0][LINE_W-1:0]  data_q [SETS];

    assign rd_vld  = vld_q[rd_set];
    assign rd_own  = own_q[rd_set];
    assign rd_tag  = tag_q[rd_set];
    assign rd_data = data_q[rd_set];
    assign pk_vld  = vld_q[pk_set];
    assign pk_own  = own_q[pk_set];
    assign pk_tag  = tag_q[pk_set];

    // Valid bits: reset clear, per-thread flush, then fill set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else begin
            if (flush_en) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_q[s] <= vld_q[s] & (flush_tid ? ~own_q[s] : own_q[s]);
                end
            end
            if (wr_en) begin
                vld_q[wr_set][wr_way] <= 1'b1;
            end
        end
    end

    // Payload: tag, owner and line written on a fill.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            own_q[wr_set][wr_way]  <= wr_own;
            data_q[wr_set][wr_way] <= wr_line;
        end
    end
endmodule

// File: rtl/dtc_lru.sv
// Exact least-recently-used order per set, kept as age counters.
// Age 0 is the newest way and age WAYS-1 the oldest. The ages of a set are
// always a permutation of 0..WAYS-1. A touch zeroes the touched way and ages
// every way that was younger. A fill touch and a hit touch to the same set in
// one cycle keep only the fill. Assumes WAYS is a power of two, at least 2.
module dtc_lru #(
    parameter int unsigned WAYS = 8,
    parameter int unsigned SETS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_en,
    input  logic [$clog2(SETS)-1:0]  hit_set,
    input  logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     fill_en,
    input  logic [$clog2(SETS)-1:0]  fill_set,
    input  logic [$clog2(WAYS)-1:0]  fill_way,
    input  logic [$clog2(SETS)-1:0]  pk_set,
    output logic [$clog2(WAYS)-1:0]  victim_way
);
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned IDX_W = $clog2(SETS);

    typedef logic [WAYS-1:0][WAY_W-1:0] age_row_t;

    age_row_t age_q [SETS];

    function automatic age_row_t touch(input age_row_t row, input logic [WAY_W-1:0] way);
        age_row_t nxt;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == way) begin
                nxt[w] = '0;
            end else if (row[w] < row[way]) begin
                nxt[w] = row[w] + 1'b1;
            end else begin
                nxt[w] = row[w];
            end
        end
        return nxt;
    endfunction

    // Update ages of the set touched by a fill or a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                if (fill_en && fill_set == IDX_W'(s)) begin
                    age_q[s] <= touch(age_q[s], fill_way);
                end else if (hit_en && hit_set == IDX_W'(s)) begin
                    age_q[s] <= touch(age_q[s], hit_way);
                end
            end
        end
    end

    // Oldest way of the probed set.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (age_q[pk_set][w] == WAY_W'(WAYS - 1)) begin
                victim_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/dtc_cache_top.sv
// Two-thread shared set-associative lookup cache.
// The arbiter grants one thread per cycle. The granted pointer is matched
// against the set's tags and owner bits, and the result is registered one
// cycle later. A fill chooses the way holding the same thread and address,
// else the lowest invalid way, else the LRU way. Address split: low
// $clog2(SETS) bits are the set index and the rest is the tag.
module dtc_cache_top
    import dtc_pkg::*;
#(
    parameter int unsigned WAYS   = 8,
    parameter int unsigned SETS   = 16,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t0_req,
    input  logic              t0_stall,
    input  logic [ADDR_W-1:0] t0_ptr,
    input  logic              t1_req,
    input  logic              t1_stall,
    input  logic [ADDR_W-1:0] t1_ptr,
    input  logic              fill_valid,
    input  logic              fill_tid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              flush_valid,
    input  logic              flush_tid,
    output logic [1:0]        grant,
    output logic              rsp_valid,
    output logic              rsp_tid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [LINE_W-1:0] rsp_line
);
    localparam int unsigned IDX_W = $clog2(SETS);
    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;

    grant_t                      gnt;
    thread_e                     sel_tid;
    logic                        any_gnt;
    logic [ADDR_W-1:0]           sel_addr;
    logic [IDX_W-1:0]            sel_set;
    logic [TAG_W-1:0]            sel_tag;
    logic [IDX_W-1:0]            fl_set;
    logic [TAG_W-1:0]            fl_tag;
    logic [WAYS-1:0]             rd_vld, rd_own, pk_vld, pk_own;
    logic [WAYS-1:0][TAG_W-1:0]  rd_tag, pk_tag;
    logic [WAYS-1:0][LINE_W-1:0] rd_data;
    logic [WAYS-1:0]             hit_vec, same_vec;
    logic [WAY_W-1:0]            hit_way, same_way, free_way, victim_way, fill_way;
    logic                        free_any;
    logic [LINE_W-1:0]           hit_line;

    dtc_arbiter i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   ({t1_req, t0_req}),
        .stall ({t1_stall, t0_stall}),
        .grant (gnt)
    );

    assign grant    = gnt;
    assign any_gnt  = |gnt;
    assign sel_tid  = gnt[1] ? THR1 : THR0;
    assign sel_addr = gnt[1] ? t1_ptr : t0_ptr;
    assign sel_set  = sel_addr[IDX_W-1:0];
    assign sel_tag  = sel_addr[ADDR_W-1:IDX_W];
    assign fl_set   = fill_addr[IDX_W-1:0];
    assign fl_tag   = fill_addr[ADDR_W-1:IDX_W];

    dtc_way_store #(
        .WAYS   (WAYS),
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_set    (sel_set),
        .rd_vld    (rd_vld),
        .rd_own    (rd_own),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .pk_set    (fl_set),
        .pk_vld    (pk_vld),
        .pk_own    (pk_own),
        .pk_tag    (pk_tag),
        .wr_en     (fill_valid),
        .wr_set    (fl_set),
        .wr_way    (fill_way),
        .wr_tag    (fl_tag),
        .wr_own    (fill_tid),
        .wr_line   (fill_line),
        .flush_en  (flush_valid),
        .flush_tid (flush_tid)
    );

    // Per-way matches: lookup hit vector and fill-side same-entry vector.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_match
            assign hit_vec[w]  = rd_vld[w] && (rd_own[w] == sel_tid) && (rd_tag[w] == sel_tag);
            assign same_vec[w] = pk_vld[w] && (pk_own[w] == fill_tid) && (pk_tag[w] == fl_tag);
        end
    endgenerate

    // Encode the hit way and select its line.
    always_comb begin
        hit_way  = '0;
        hit_line = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_way  = WAY_W'(w);
                hit_line = rd_data[w];
            end
        end
    end

    // Encode the lowest same-entry way and the lowest invalid way.
    always_comb begin
        same_way = '0;
        free_way = '0;
        free_any = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (same_vec[w]) begin
                same_way = WAY_W'(w);
            end
            if (!pk_vld[w]) begin
                free_way = WAY_W'(w);
                free_any = 1'b1;
            end
        end
    end

    // Fill way: in-place overwrite, then invalid way, then LRU way.
    always_comb begin
        if (|same_vec) begin
            fill_way = same_way;
        end else if (free_any) begin
            fill_way = free_way;
        end else begin
            fill_way = victim_way;
        end
    end

    dtc_lru #(
        .WAYS (WAYS),
        .SETS (SETS)
    ) i_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_en     (any_gnt && (|hit_vec)),
        .hit_set    (sel_set),
        .hit_way    (hit_way),
        .fill_en    (fill_valid),
        .fill_set   (fl_set),
        .fill_way   (fill_way),
        .pk_set     (fl_set),
        .victim_way (victim_way)
    );

    // Register the lookup result one cycle after the grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tid   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_line  <= '0;
        end else begin
            rsp_valid <= any_gnt;
            rsp_tid   <= sel_tid;
            rsp_hit   <= any_gnt && (|hit_vec);
            rsp_line  <= (any_gnt && (|hit_vec)) ? hit_line : '0;
        end
    end

    assign rsp_miss = rsp_valid && !rsp_hit;
endmodule

// File: rtl/dtc_checker.sv
// Protocol checks for the two-thread lookup cache, bound to the top module.
// Observes only the top-level ports.
module dtc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       t0_req,
    input logic       t0_stall,
    input logic       t1_req,
    input logic       t1_stall,
    input logic [1:0] grant,
    input logic       rsp_valid,
    input logic       rsp_tid,
    input logic       rsp_hit,
    input logic       rsp_miss
);
    logic e0, e1;
    assign e0 = t0_req && !t0_stall;
    assign e1 = t1_req && !t1_stall;

    a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r2_grant_t0_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> e0);

    a_r2_grant_t1_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> e1);

    a_r3_solo_t0: assert property (@(posedge clk) disable iff (!rst_n)
        (e0 && !e1) |-> (grant == 2'b01));

    a_r3_solo_t1: assert property (@(posedge clk) disable iff (!rst_n)
        (e1 && !e0) |-> (grant == 2'b10));

    a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (e0 && e1 && $past(e0 && e1) && $past(rst_n)) |-> (grant != $past(grant)));

    a_r5_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (rsp_valid && rsp_tid == $past(grant[1])));

    a_r5_no_rsp_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b00) |=> !rsp_valid);

    a_r5_hit_miss_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss));
endmodule

bind dtc_cache_top dtc_checker i_dtc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .t0_req    (t0_req),
    .t0_stall  (t0_stall),
    .t1_req    (t1_req),
    .t1_stall  (t1_stall),
    .grant     (grant),
    .rsp_valid (rsp_valid),
    .rsp_tid   (rsp_tid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss)
);

// File: tb/test_dtc_cache_top.sv
`timescale 1ns/1ps
module test_dtc_cache_top;
    localparam int unsigned WAYS   = 8;
    localparam int unsigned SETS   = 4;
    localparam int unsigned ADDR_W = 10;
    localparam int unsigned LINE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              t0_req = 1'b0, t0_stall = 1'b0, t1_req = 1'b0, t1_stall = 1'b0;
    logic [ADDR_W-1:0] t0_ptr = '0, t1_ptr = '0;
    logic              fill_valid = 1'b0, fill_tid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [LINE_W-1:0] fill_line = '0;
    logic              flush_valid = 1'b0, flush_tid = 1'b0;
    logic [1:0]        grant;
    logic              rsp_valid, rsp_tid, rsp_hit, rsp_miss;
    logic [LINE_W-1:0] rsp_line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dtc_cache_top #(
        .WAYS (WAYS), .SETS (SETS), .ADDR_W (ADDR_W), .LINE_W (LINE_W)
    ) i_dtc_cache_top (
        .clk (clk), .rst_n (rst_n),
        .t0_req (t0_req), .t0_stall (t0_stall), .t0_ptr (t0_ptr),
        .t1_req (t1_req), .t1_stall (t1_stall), .t1_ptr (t1_ptr),
        .fill_valid (fill_valid), .fill_tid (fill_tid), .fill_addr (fill_addr), .fill_line (fill_line),
        .flush_valid (flush_valid), .flush_tid (flush_tid),
        .grant (grant), .rsp_valid (rsp_valid), .rsp_tid (rsp_tid),
        .rsp_hit (rsp_hit), .rsp_miss (rsp_miss), .rsp_line (rsp_line)
    );

    // Arbitration vectors {t0_req, t0_stall, t1_req, t1_stall, grant[1], grant[0]}.
    localparam int NVEC = 11;
    localparam logic [5:0] VEC [NVEC] = '{
        6'b101001, 6'b101010, 6'b100001, 6'b101001, 6'b111010, 6'b101101,
        6'b001010, 6'b101010, 6'b000000, 6'b111100, 6'b101001
    };

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
        return {8'(tag), 2'(set)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic chk_rsp(input logic tid, input logic hit, input logic [LINE_W-1:0] line, input string rq);
        chk(rsp_valid && rsp_tid == tid, rq, {rsp_valid, rsp_tid}, {1'b1, tid});
        chk(rsp_hit == hit && rsp_miss == !hit, rq, {rsp_hit, rsp_miss}, {hit, !hit});
        chk(rsp_line == line, rq, 32'(rsp_line), 32'(line));
    endtask

    task automatic look(input logic tid, input logic [ADDR_W-1:0] a, input logic hit,
                        input logic [LINE_W-1:0] line, input string rq);
        @(negedge clk);
        if (tid) begin t1_req = 1'b1; t1_ptr = a; end
        else     begin t0_req = 1'b1; t0_ptr = a; end
        @(posedge clk); #1;
        t0_req = 1'b0; t1_req = 1'b0;
        chk_rsp(tid, hit, line, rq);
    endtask

    task automatic fill(input logic tid, input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] line);
        @(negedge clk);
        fill_valid = 1'b1; fill_tid = tid; fill_addr = a; fill_line = line;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!rsp_valid && !rsp_hit && !rsp_miss, "R1 reset response", {rsp_valid, rsp_hit, rsp_miss}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table: R2, R3, R4 grants and R5 responses (empty cache, misses: R1).
        t0_ptr = mk(1, 0); t1_ptr = mk(1, 0);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {t0_req, t0_stall, t1_req, t1_stall} = VEC[i][5:2];
            #1;
            chk(grant == VEC[i][1:0], "R2 R3 R4 grant", 32'(grant), 32'(VEC[i][1:0]));
            @(posedge clk); #1;
            if (VEC[i][1:0] == 2'b00) begin
                chk(!rsp_valid, "R5 no grant no response", 32'(rsp_valid), 0);
            end else begin
                chk_rsp(VEC[i][1], 1'b0, '0, "R1 R5 response after grant");
            end
        end
        @(negedge clk);
        {t0_req, t0_stall, t1_req, t1_stall} = 4'b0000;

        // Owner-tagged hits (R5, R6, R7).
        look(0, mk(5, 1), 0, 16'h0000, "R1 first lookup misses");
        fill(0, mk(5, 1), 16'hA0A0);
        look(0, mk(5, 1), 1, 16'hA0A0, "R5 hit returns line");
        look(1, mk(5, 1), 0, 16'h0000, "R6 other thread misses");
        fill(1, mk(5, 1), 16'hB1B1);
        look(1, mk(5, 1), 1, 16'hB1B1, "R6 thread 1 own line");
        look(0, mk(5, 1), 1, 16'hA0A0, "R6 thread 0 line kept");
        fill(0, mk(5, 1), 16'hC2C2);
        look(0, mk(5, 1), 1, 16'hC2C2, "R7 overwrite in place");

        // Fill the set (R7) then evict by LRU (R8).
        for (int t = 10; t < 16; t++) fill(0, mk(t, 1), 16'(16'h1000 + t));
        look(1, mk(5, 1), 1, 16'hB1B1, "R7 in-place overwrite kept thread 1 line");
        fill(0, mk(20, 1), 16'hD3D3);
        look(0, mk(5, 1), 0, 16'h0000, "R8 least recent way evicted");
        look(1, mk(5, 1), 1, 16'hB1B1, "R8 refreshed way survives");
        look(0, mk(20, 1), 1, 16'hD3D3, "R8 new line present");
        look(0, mk(10, 1), 1, 16'h100A, "R8 other ways intact");

        // Same-cycle fill and lookup (R10).
        @(negedge clk);
        fill_valid = 1'b1; fill_tid = 1'b1; fill_addr = mk(30, 3); fill_line = 16'hE4E4;
        t1_req = 1'b1; t1_ptr = mk(30, 3);
        @(posedge clk); #1;
        fill_valid = 1'b0; t1_req = 1'b0;
        chk_rsp(1, 0, '0, "R10 lookup beside fill sees old contents");
        look(1, mk(30, 3), 1, 16'hE4E4, "R10 fill visible next cycle");

        // Selective flush (R9).
        fill(0, mk(7, 2), 16'h7777);
        @(negedge clk); flush_valid = 1'b1; flush_tid = 1'b0;
        @(posedge clk); #1; flush_valid = 1'b0;
        look(0, mk(10, 1), 0, 16'h0000, "R9 thread 0 set 1 flushed");
        look(0, mk(7, 2), 0, 16'h0000, "R9 thread 0 set 2 flushed");
        look(1, mk(5, 1), 1, 16'hB1B1, "R9 thread 1 entry kept");

        // Same-cycle flush and lookup (R10, R9).
        @(negedge clk);
        flush_valid = 1'b1; flush_tid = 1'b1;
        t1_req = 1'b1; t1_ptr = mk(5, 1);
        @(posedge clk); #1;
        flush_valid = 1'b0; t1_req = 1'b0;
        chk_rsp(1, 1, 16'hB1B1, "R10 lookup beside flush sees old contents");
        look(1, mk(5, 1), 0, 16'h0000, "R9 thread 1 flushed");
        look(1, mk(30, 3), 0, 16'h0000, "R9 thread 1 set 3 flushed");

        // Refill after flush uses a free way (R7).
        fill(0, mk(40, 1), 16'hF5F5);
        look(0, mk(40, 1), 1, 16'hF5F5, "R7 fill into free way");
        look(0, mk(20, 1), 0, 16'h0000, "R9 flushed line stays gone");

        summary();
    end
endmodule